// File: doc/BRIEF.md
# Double-Buffered Crosspoint Bit Switch

This block routes single-bit data between N input lanes and N output lanes. Each output owns a selection entry. The entry holds an enable flag and the index of the input lane that drives the output. Because every output picks its source independently, no connection can block another. One input may feed any number of outputs.

Routing entries are written one at a time into a pending (shadow) bank through an address/data write port. None of these writes touches the traffic. A single `commit` strobe copies the whole pending bank into the live (active) bank in one clock edge, so a complete new routing takes effect at once. A readback port returns the entry of either bank. It is used to confirm a configuration before it is committed, or to confirm afterwards that it is live. Output data is registered.

Top module: `xbar_dbuf`

## Requirements
- R1: While `rst` is high at a clock edge, both banks are cleared. All outputs then read 0 at `dout` and `rd_data` reads 0 on the following cycle.
- R2: When the live entry of output o is enabled with source s, `dout[o]` equals the value `din[s]` had at the previous rising edge. This is one cycle of latency.
- R3: When the live entry of output o is disabled, `dout[o]` is 0 one cycle later, whatever `din` is.
- R4: Several outputs may name the same source at once, and each of them follows that input.
- R5: A write (`cfg_we` high) stores `{cfg_on, cfg_src}` into the pending entry of output `cfg_idx`. It does not change the live bank or `dout` until `commit` is sampled high.
- R6: When `commit` is high at an edge, every live entry takes the value its pending entry held before that edge, all in the same edge.
- R7: A write and a commit in the same cycle commit the pending bank as it stood before the write. The new write stays pending until a later commit.
- R8: `rd_data` is `{enable, source}`, with enable at bit SW and the source index in bits SW-1:0. It is taken from entry `rd_idx` of the pending bank when `rd_bank` is 0, or of the live bank when `rd_bank` is 1. It appears on the cycle after the address is presented.
- R9: The matrix is non-blocking: any combination of sources across outputs, including arbitrary random ones, routes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | N | Input lanes |
| dout | output | N | Registered output lanes |
| cfg_we | input | 1 | Write strobe for the pending bank |
| cfg_idx | input | SW | Output whose pending entry is written |
| cfg_on | input | 1 | Enable flag written |
| cfg_src | input | SW | Source index written |
| commit | input | 1 | Copy the pending bank into the live bank |
| rd_idx | input | SW | Entry to read back |
| rd_bank | input | 1 | 0 = pending bank, 1 = live bank |
| rd_data | output | SW+1 | Registered readback `{enable, source}` |

## Verification
The checker tests on every cycle the behaviour of the live bank. The live bank holds still without a commit, takes the whole pending bank in the edge after a commit, and reset clears the outputs. Each output either follows its selected input with one cycle of latency or is 0 when disabled. The bench alone covers readback formatting and latency, since both depend on the bank choice. It also covers the collision of a write with a commit, and fanout of one input to many outputs. It checks the full routing under random reconfiguration against a reference model of both banks.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    BANK_PENDING = 1'b0,
    BANK_LIVE    = 1'b1
  } bank_e;
endpackage

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank #(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_idx,
  input  logic            cfg_on,
  input  logic [SW-1:0]   cfg_src,
  input  logic            commit,
  output logic [N-1:0]    pnd_on,
  output logic [N*SW-1:0] pnd_src,
  output logic [N-1:0]    live_on,
  output logic [N*SW-1:0] live_src
);
  for (genvar o = 0; o < N; o++) begin : g_entry
    logic hit;
    assign hit = cfg_we && (cfg_idx == SW'(o));

    always_ff @(posedge clk) begin
      if (rst) begin
        pnd_on[o]             <= 1'b0;
        pnd_src[o*SW +: SW]   <= '0;
        live_on[o]            <= 1'b0;
        live_src[o*SW +: SW]  <= '0;
      end else begin
        if (hit) begin
          pnd_on[o]           <= cfg_on;
          pnd_src[o*SW +: SW] <= cfg_src;
        end
        if (commit) begin
          live_on[o]           <= pnd_on[o];
          live_src[o*SW +: SW] <= pnd_src[o*SW +: SW];
        end
      end
    end
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    din,
  input  logic [N-1:0]    live_on,
  input  logic [N*SW-1:0] live_src,
  output logic [N-1:0]    dout
);
  for (genvar o = 0; o < N; o++) begin : g_out
    logic [SW-1:0] sel;
    logic          bit_nxt;
    assign sel     = live_src[o*SW +: SW];
    assign bit_nxt = live_on[o] & din[sel];

    always_ff @(posedge clk) begin
      if (rst) dout[o] <= 1'b0;
      else     dout[o] <= bit_nxt;
    end
  end
endmodule

// File: rtl/xbar_readback.sv
module xbar_readback
  import xbar_pkg::*;
#(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW-1:0]   rd_idx,
  input  logic            rd_bank,
  input  logic [N-1:0]    pnd_on,
  input  logic [N*SW-1:0] pnd_src,
  input  logic [N-1:0]    live_on,
  input  logic [N*SW-1:0] live_src,
  output logic [SW:0]     rd_data
);
  logic [SW:0] pnd_word, live_word;

  assign pnd_word  = {pnd_on[rd_idx],  pnd_src[rd_idx*SW +: SW]};
  assign live_word = {live_on[rd_idx], live_src[rd_idx*SW +: SW]};

  always_ff @(posedge clk) begin
    if (rst)                          rd_data <= '0;
    else if (bank_e'(rd_bank) == BANK_LIVE) rd_data <= live_word;
    else                              rd_data <= pnd_word;
  end
endmodule

// File: rtl/xbar_dbuf.sv
module xbar_dbuf #(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  din,
  output logic [N-1:0]  dout,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_idx,
  input  logic          cfg_on,
  input  logic [SW-1:0] cfg_src,
  input  logic          commit,
  input  logic [SW-1:0] rd_idx,
  input  logic          rd_bank,
  output logic [SW:0]   rd_data
);
  logic [N-1:0]    pnd_on, live_on;
  logic [N*SW-1:0] pnd_src, live_src;

  xbar_cfg_bank #(.N(N), .SW(SW)) u_bank (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_on(cfg_on), .cfg_src(cfg_src),
    .commit(commit),
    .pnd_on(pnd_on), .pnd_src(pnd_src),
    .live_on(live_on), .live_src(live_src)
  );

  xbar_route #(.N(N), .SW(SW)) u_route (
    .clk(clk), .rst(rst), .din(din),
    .live_on(live_on), .live_src(live_src),
    .dout(dout)
  );

  xbar_readback #(.N(N), .SW(SW)) u_rb (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_bank(rd_bank),
    .pnd_on(pnd_on), .pnd_src(pnd_src),
    .live_on(live_on), .live_src(live_src),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/xbar_dbuf_chk.sv
module xbar_dbuf_chk #(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    din,
  input logic [N-1:0]    dout,
  input logic            commit,
  input logic [N-1:0]    pnd_on,
  input logic [N*SW-1:0] pnd_src,
  input logic [N-1:0]    live_on,
  input logic [N*SW-1:0] live_src
);
  // R1: reset clears the outputs on the next cycle
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dout == '0 && live_on == '0 && pnd_on == '0));

  // R5: live bank holds without a commit
  assert_live_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(live_on) && $stable(live_src)));

  // R6: commit copies the whole pending bank in one edge
  assert_commit_copy_R6: assert property (@(posedge clk) disable iff (rst)
    commit |=> (live_on == $past(pnd_on) && live_src == $past(pnd_src)));

  for (genvar o = 0; o < N; o++) begin : g_chk
    // R2: enabled output follows its source one cycle later
    assert_route_R2: assert property (@(posedge clk) disable iff (rst)
      live_on[o] |=> (dout[o] == $past(din[live_src[o*SW +: SW]])));
    // R3: disabled output drives 0
    assert_off_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !live_on[o] |=> (dout[o] == 1'b0));
  end
endmodule

bind xbar_dbuf xbar_dbuf_chk #(.N(N), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .din(din), .dout(dout), .commit(commit),
  .pnd_on(pnd_on), .pnd_src(pnd_src),
  .live_on(live_on), .live_src(live_src)
);

// File: tb/xbar_dbuf_bench.sv
`timescale 1ns/1ps
module xbar_dbuf_bench;
  localparam int N  = 16;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  din;
  logic [N-1:0]  dout;
  logic          cfg_we, cfg_on, commit, rd_bank;
  logic [SW-1:0] cfg_idx, cfg_src, rd_idx;
  logic [SW:0]   rd_data;

  always #10 clk = ~clk;

  xbar_dbuf #(.N(N)) u_xbar_dbuf (
    .clk(clk), .rst(rst), .din(din), .dout(dout),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_on(cfg_on), .cfg_src(cfg_src),
    .commit(commit), .rd_idx(rd_idx), .rd_bank(rd_bank), .rd_data(rd_data)
  );

  // reference model
  logic [SW:0] m_pnd [N];
  logic [SW:0] m_live[N];
  logic [N-1:0] exp_dout;
  logic [SW:0]  exp_rd;
  int n_tests = 0, n_fail = 0;
  string phase = "R1";

  function automatic logic [N-1:0] route_model(input logic [N-1:0] d);
    logic [N-1:0] r = '0;
    for (int o = 0; o < N; o++)
      r[o] = m_live[o][SW] ? d[m_live[o][SW-1:0]] : 1'b0;
    return r;
  endfunction

  task automatic idle_inputs();
    cfg_we = 0; cfg_idx = '0; cfg_on = 0; cfg_src = '0;
    commit = 0; rd_idx = '0; rd_bank = 0;
  endtask

  // one clock: advance model with inputs present before edge, then compare
  task automatic step();
    logic [N-1:0] d_now;
    logic [SW:0]  pnd_old[N];
    d_now = din;
    for (int i = 0; i < N; i++) pnd_old[i] = m_pnd[i];
    if (rst) begin
      exp_dout = '0; exp_rd = '0;
      for (int i = 0; i < N; i++) begin m_pnd[i] = '0; m_live[i] = '0; end
    end else begin
      exp_dout = route_model(d_now);
      exp_rd   = rd_bank ? m_live[rd_idx] : m_pnd[rd_idx];
      if (commit) for (int i = 0; i < N; i++) m_live[i] = pnd_old[i];
      if (cfg_we) m_pnd[cfg_idx] = {cfg_on, cfg_src};
    end
    @(posedge clk); #2;
    n_tests++;
    if (dout !== exp_dout) begin
      n_fail++;
      $display("FAIL R2 R3 %s dout actual=%h expected=%h", phase, dout, exp_dout);
    end
    n_tests++;
    if (rd_data !== exp_rd) begin
      n_fail++;
      $display("FAIL R8 %s rd_data actual=%h expected=%h", phase, rd_data, exp_rd);
    end
  endtask

  task automatic wr(input int idx, input bit on, input int src);
    cfg_we = 1; cfg_idx = SW'(idx); cfg_on = on; cfg_src = SW'(src);
    step();
    cfg_we = 0;
  endtask

  task automatic check_live(input int idx, input logic [SW:0] want, input string tag);
    rd_bank = 1; rd_idx = SW'(idx);
    step();
    n_tests++;
    if (rd_data !== want) begin
      n_fail++;
      $display("FAIL %s live[%0d] actual=%h expected=%h", tag, idx, rd_data, want);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle_inputs(); din = '1; rst = 1;
    for (int i = 0; i < N; i++) begin m_pnd[i] = '0; m_live[i] = '0; end
    phase = "R1"; step(); step();
    rst = 0; din = '1;
    phase = "R1"; step(); step(); // disabled outputs stay 0 with all-ones input

    // R5: pending writes do not reach traffic
    phase = "R5";
    for (int o = 0; o < N; o++) wr(o, 1'b1, (o + 3) % N);
    for (int k = 0; k < 4; k++) begin din = N'($urandom); step(); end
    n_tests++;
    if (dout !== '0) begin n_fail++; $display("FAIL R5 dout actual=%h expected=0", dout); end
    check_live(2, '0, "R5");

    // R6: one commit applies everything at once
    phase = "R6";
    commit = 1; step(); commit = 0;
    check_live(2, {1'b1, SW'(5)}, "R6");
    check_live(N-1, {1'b1, SW'(2)}, "R6");
    din = 16'h0001 << 5; step();
    din = '0; step();

    // R4: fanout of input 7 to every even output
    phase = "R4";
    for (int o = 0; o < N; o += 2) wr(o, 1'b1, 7);
    commit = 1; step(); commit = 0;
    din = 16'h0080; step();
    n_tests++;
    for (int o = 0; o < N; o += 2)
      if (dout[o] !== 1'b1) begin n_fail++; n_tests++;
        $display("FAIL R4 dout[%0d] actual=%b expected=1", o, dout[o]); end

    // R7: write and commit together
    phase = "R7";
    wr(4, 1'b0, 0);               // pending[4] off
    cfg_we = 1; cfg_idx = 4; cfg_on = 1; cfg_src = 9; commit = 1;
    step();
    cfg_we = 0; commit = 0;
    check_live(4, {1'b0, SW'(0)}, "R7");
    rd_bank = 0; rd_idx = 4; step();
    n_tests++;
    if (rd_data !== {1'b1, SW'(9)}) begin n_fail++;
      $display("FAIL R7 pending[4] actual=%h expected=%h", rd_data, {1'b1, SW'(9)}); end
    commit = 1; step(); commit = 0;
    check_live(4, {1'b1, SW'(9)}, "R7");

    // R8: readback both banks with distinct values
    phase = "R8";
    wr(11, 1'b1, 13);
    for (int k = 0; k < 4; k++) begin rd_bank = k[0]; rd_idx = 11; step(); end

    // R9: random non-blocking configurations
    phase = "R9";
    for (int k = 0; k < 3000; k++) begin
      din     = N'($urandom);
      cfg_we  = ($urandom % 3) == 0;
      cfg_idx = SW'($urandom); cfg_on = ($urandom % 4) != 0; cfg_src = SW'($urandom);
      commit  = ($urandom % 8) == 0;
      rd_idx  = SW'($urandom); rd_bank = $urandom % 2;
      rst     = ($urandom % 997) == 0;
      step();
    end
    rst = 0; idle_inputs();
    step();
    finish_run();
  end
endmodule